// File: doc/BRIEF.md
# Parallel EPROM Read Bus Controller

This block lets a synchronous host fetch 16-bit words from a bank of asynchronous parallel EPROM devices that share one address bus and one data bus. Every device has its own active-low chip-select. A single active-low output-enable runs to all of them. When the host issues a request, the block latches the word address and the bank number. It pulls down the one chip-select that the bank number decodes to, and later lowers the shared output-enable. After a wait, it samples the data bus and returns the word with a one-cycle valid strobe. It then keeps the bus quiet for a float gap before it accepts the next request.

The timing of each speed grade is given in nanoseconds as parameters: address/select access time, output-enable access time and output float time, together with the clock period. Each delay becomes a whole number of cycles by ceiling division, with a floor of one cycle. The output-enable is held back by the difference between the address and output-enable access counts, so it falls only when the device can answer in time. The word is captured while the address is still held.

The controller is a four-state machine:
- `ST_IDLE` raises ready and accepts a request (transition *accept*).
- `ST_SETUP` drives the address and the decoded chip-select. It leaves on *lead_done* and is skipped when the lead count is zero.
- `ST_STROBE` also lowers the output-enable and leaves on *sample*, which captures the bus.
- `ST_FLOAT` releases every enable and returns to idle on *float_done*.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, ready is 1, every chip-select is 1 (inactive), output-enable is 1 and rvalid is 0.
- R2: During an access, exactly the chip-select whose index equals the latched bank number is 0 and all others stay 1. At no time is more than one chip-select 0.
- R3: Output-enable is 0 only while a chip-select is 0. It falls max(ACC−OE, 0) cycles after the chip-select falls, where ACC and OE are the converted access counts.
- R4: rvalid is high for exactly one cycle, ACC cycles after the clock edge that accepted the request. rdata then carries the data bus word sampled on that edge, while output-enable and chip-select were still low.
- R5: The address output holds the accepted word address, unchanged, for the whole time a chip-select is low.
- R6: After the sampling edge, all chip-selects and the output-enable stay high and ready stays low for DF cycles (the converted float time). Ready returns after that. Ready is low from the accept edge until then.
- R7: A request presented while ready is low has no effect: it produces no extra rvalid, and the next accepted request returns its own word.
- R8: Each nanosecond delay converts to cycles as ceil(ns / clock period), minimum 1. With an 8 ns clock, 120/60/50 ns give ACC=15, OE=8 and DF=7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host read request, taken when ready is 1 |
| req_addr | input | ADDR_W (18) | Word address within a device |
| req_bank | input | BANK_W (2) | Device index |
| ready | output | 1 | Controller idle and able to accept |
| rdata | output | DATA_W (16) | Returned word |
| rvalid | output | 1 | One-cycle strobe marking rdata valid |
| mem_addr | output | ADDR_W (18) | Address bus to the devices |
| mem_ce_n | output | N_DEV (4) | Per-device chip-selects, active low |
| mem_oe_n | output | 1 | Shared output-enable, active low |
| mem_dq_in | input | DATA_W (16) | Data bus from the devices |

## Verification
The bench builds the block with an 8 ns clock and the fastest grade (120/60/50 ns) across four devices. With these values the output-enable and float conversions round up (7.5 to 8, 6.25 to 7), and the lead phase is nonzero, so all four states are visited. The bench's device model returns a known word only once select, output-enable and address have each been steady for the converted counts, and returns a garbage word otherwise. Any shortened wait, wrong decode or early address change therefore shows up as a data miscompare, alongside direct cycle-count checks on the lead, latency and float gap.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_FLOAT
    } rd_state_e;

    // Convert a delay in ns to clock cycles: ceiling division, floor of one.
    function automatic int unsigned ns_to_cyc(input int unsigned dly_ns,
                                              input int unsigned clk_ns);
        int unsigned c;
        c = (dly_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/eprom_cs_decode.sv
module eprom_cs_decode #(
    parameter int unsigned N_DEV  = 4,
    parameter int unsigned BANK_W = 2
) (
    input  logic [BANK_W-1:0] bank,
    input  logic              en,
    output logic [N_DEV-1:0]  ce_n
);
    for (genvar g = 0; g < N_DEV; g++) begin : g_sel
        assign ce_n[g] = !(en && (bank == BANK_W'(g)));
    end
endmodule

// File: rtl/eprom_wait_ctr.sv
module eprom_wait_ctr #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= cap;
            if (cap) rdata <= dq_in;
        end
    end
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int unsigned CLK_NS   = 8,
    parameter int unsigned T_ACC_NS = 120,
    parameter int unsigned T_OE_NS  = 60,
    parameter int unsigned T_DF_NS  = 50,
    parameter int unsigned N_DEV    = 4,
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned DATA_W   = 16,
    localparam int unsigned BANK_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BANK_W-1:0] req_bank,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [N_DEV-1:0]  mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned ACC_CYC  = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned OE_CYC   = ns_to_cyc(T_OE_NS, CLK_NS);
    localparam int unsigned DF_CYC   = ns_to_cyc(T_DF_NS, CLK_NS);
    localparam int unsigned LEAD_CYC = (ACC_CYC > OE_CYC) ? (ACC_CYC - OE_CYC) : 0;
    localparam int unsigned MAX_CYC  = max3(ACC_CYC, OE_CYC, DF_CYC);
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] OE_LOAD    = CNT_W'(OE_CYC - 1);
    localparam logic [CNT_W-1:0] DF_LOAD    = CNT_W'(DF_CYC - 1);
    localparam logic [CNT_W-1:0] FIRST_LOAD = (LEAD_CYC > 0) ? CNT_W'(LEAD_CYC - 1) : OE_LOAD;
    localparam rd_state_e        FIRST_ST   = (LEAD_CYC > 0) ? ST_SETUP : ST_STROBE;

    rd_state_e         st_q, st_d;
    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic              wait_done;
    logic              cap;
    logic              accept;
    logic              ce_en;
    logic [ADDR_W-1:0] addr_q;
    logic [BANK_W-1:0] bank_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state and counter control
    always_comb begin
        st_d   = st_q;
        ld     = 1'b0;
        ld_val = '0;
        cap    = 1'b0;
        accept = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    ld     = 1'b1;
                    ld_val = FIRST_LOAD;
                    st_d   = FIRST_ST;
                end
            end
            ST_SETUP: begin
                if (wait_done) begin
                    ld     = 1'b1;
                    ld_val = OE_LOAD;
                    st_d   = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (wait_done) begin
                    cap    = 1'b1;
                    ld     = 1'b1;
                    ld_val = DF_LOAD;
                    st_d   = ST_FLOAT;
                end
            end
            ST_FLOAT: begin
                if (wait_done) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        ready    = 1'b0;
        ce_en    = 1'b0;
        mem_oe_n = 1'b1;
        unique case (st_q)
            ST_IDLE:   ready = 1'b1;
            ST_SETUP:  ce_en = 1'b1;
            ST_STROBE: begin
                ce_en    = 1'b1;
                mem_oe_n = 1'b0;
            end
            ST_FLOAT:  ;
            default:   ;
        endcase
    end

    // Request latch: address and bank stay fixed until the next accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            bank_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            bank_q <= req_bank;
        end
    end

    assign mem_addr = addr_q;

    eprom_wait_ctr #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .done     (wait_done)
    );

    eprom_cs_decode #(.N_DEV(N_DEV), .BANK_W(BANK_W)) u_dec (
        .bank (bank_q),
        .en   (ce_en),
        .ce_n (mem_ce_n)
    );

    eprom_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .dq_in  (mem_dq_in),
        .rdata  (rdata),
        .rvalid (rvalid)
    );
endmodule

// File: rtl/eprom_rd_ctrl_chk.sv
module eprom_rd_ctrl_chk #(
    parameter int unsigned N_DEV  = 4,
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DF_CYC = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [N_DEV-1:0]  mem_ce_n,
    input logic              mem_oe_n
);
    localparam logic [N_DEV-1:0] ALL_HI = '1;

    logic        sel_any;
    logic [15:0] quiet_cnt;

    assign sel_any = (mem_ce_n != ALL_HI);

    // Consecutive cycles with every enable released; bus starts quiet at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= 16'(DF_CYC);
        end else if (!sel_any && mem_oe_n) begin
            if (quiet_cnt != 16'hFFFF) quiet_cnt <= quiet_cnt + 1'b1;
        end else begin
            quiet_cnt <= '0;
        end
    end

    assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_ce_n) <= 1);

    assert_oe_under_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> sel_any);

    assert_rvalid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    assert_addr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_any && $past(sel_any)) |-> $stable(mem_addr));

    assert_float_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_any && !$past(sel_any)) |-> (quiet_cnt >= 16'(DF_CYC)));

    assert_busy_on_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !ready);
endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(
    .N_DEV  (N_DEV),
    .ADDR_W (ADDR_W),
    .DF_CYC (DF_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .rvalid   (rvalid),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n)
);

// File: tb/tb_eprom_rd_ctrl.sv
module tb_eprom_rd_ctrl;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int ND = 4;
    // Expected cycle counts, ceil(ns/8) worked out by hand (R8)
    localparam int E_ACC  = 15;
    localparam int E_OE   = 8;
    localparam int E_DF   = 7;
    localparam int E_LEAD = E_ACC - E_OE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_bank = '0;
    logic          ready, rvalid, mem_oe_n;
    logic [DW-1:0] rdata, mem_dq_in;
    logic [AW-1:0] mem_addr;
    logic [ND-1:0] mem_ce_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eprom_rd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_bank(req_bank), .ready(ready), .rdata(rdata), .rvalid(rvalid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_dq_in(mem_dq_in)
    );

    function automatic logic [DW-1:0] pat(input logic [1:0] b, input logic [AW-1:0] a);
        return a[15:0] ^ {a[17:16], 12'h5A3, b};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Device model: word valid only after select, OE and address steady long enough.
    int            ce_cnt = 0, oe_cnt = 0, ad_cnt = 0;
    logic [ND-1:0] ce_prev = '1;
    logic [AW-1:0] ad_prev = '0;
    always @(negedge clk) begin
        if (&mem_ce_n) ce_cnt <= 0;
        else if (mem_ce_n != ce_prev) ce_cnt <= 1;
        else ce_cnt <= ce_cnt + 1;
        if (mem_oe_n) oe_cnt <= 0; else oe_cnt <= oe_cnt + 1;
        if (mem_addr != ad_prev) ad_cnt <= 1;
        else if (ad_cnt < 1000) ad_cnt <= ad_cnt + 1;
        ce_prev <= mem_ce_n;
        ad_prev <= mem_addr;
    end
    always_comb begin
        logic [1:0] idx;
        idx = '0;
        for (int i = 0; i < ND; i++) if (!mem_ce_n[i]) idx = 2'(i);
        if ($countones(~mem_ce_n) == 1 && !mem_oe_n && ce_cnt >= E_ACC &&
            oe_cnt >= E_OE && ad_cnt >= E_ACC)
            mem_dq_in = pat(idx, mem_addr);
        else
            mem_dq_in = 16'hDEAD;
    end

    // Scoreboard
    logic [19:0] exp_q[$];
    int          acc_q[$];
    int          n_rv = 0;

    task automatic rd(input logic [1:0] b, input logic [AW-1:0] a);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_bank = b; req_addr = a;
        exp_q.push_back({b, a});
        @(negedge clk);
        acc_q.push_back(cyc);
        chk(!ready, "R6", "ready low after accept", 32'(ready), 0);
        req = 1'b0;
    endtask

    // Request while busy (R7)
    task automatic poke(input logic [AW-1:0] a);
        @(negedge clk);
        req = 1'b1; req_bank = 2'd3; req_addr = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    // Monitor
    int            ce_fall = 0, oe_fall = 0, rv_cyc = 0;
    logic [ND-1:0] ce_seen = '1, prev_ce = '1;
    logic [AW-1:0] ad_at_ce = '0;
    bit            ad_moved = 0, prev_oe = 1, in_gap = 0, gap_bad = 0, prev_rst = 0;
    always @(negedge clk) begin
        if (prev_rst && rst_n) begin
            if (!(&mem_ce_n) && (&prev_ce)) begin
                ce_fall = cyc; ad_at_ce = mem_addr; ad_moved = 0;
            end
            if (!(&mem_ce_n) && mem_addr != ad_at_ce) ad_moved = 1;
            if (!mem_oe_n && prev_oe) begin
                oe_fall = cyc; ce_seen = mem_ce_n;
            end
            if (rvalid) begin
                n_rv++;
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "rvalid with nothing outstanding", 1, 0);
                end else begin
                    logic [19:0] e;
                    int          ac;
                    e  = exp_q.pop_front();
                    ac = acc_q.pop_front();
                    chk(rdata == pat(e[19:18], e[17:0]), "R4", "returned word",
                        32'(rdata), 32'(pat(e[19:18], e[17:0])));
                    chk(cyc - ac == E_ACC, "R4", "latency", 32'(cyc - ac), E_ACC);
                    chk(ce_seen == ~(4'b1 << e[19:18]), "R2", "select decode",
                        32'(ce_seen), 32'(~(4'b1 << e[19:18])));
                    chk(oe_fall - ce_fall == E_LEAD, "R3", "oe lead",
                        32'(oe_fall - ce_fall), E_LEAD);
                    chk(cyc - oe_fall == E_OE, "R8", "oe window",
                        32'(cyc - oe_fall), E_OE);
                    chk(!ad_moved && ad_at_ce == e[17:0], "R5", "address held",
                        32'(ad_at_ce), 32'(e[17:0]));
                end
                chk(!ready, "R6", "ready during valid", 32'(ready), 0);
                rv_cyc = cyc; in_gap = 1; gap_bad = 0;
            end else if (in_gap) begin
                if (!(&mem_ce_n) || !mem_oe_n) gap_bad = 1;
                if (ready) begin
                    chk(cyc - rv_cyc == E_DF && !gap_bad, "R6", "float gap",
                        32'(cyc - rv_cyc), E_DF);
                    in_gap = 0;
                end
            end
        end
        prev_ce  = mem_ce_n;
        prev_oe  = mem_oe_n;
        prev_rst = rst_n;
    end

    initial begin
        bit timeout;
        timeout = 0;
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                chk(ready && (&mem_ce_n) && mem_oe_n && !rvalid, "R1", "reset outputs",
                    {28'(0), ready, mem_oe_n, rvalid, &mem_ce_n}, 32'b1101);
                rst_n = 1'b1;
                rd(2'd0, 18'h00000);
                rd(2'd1, 18'h3FFFF);
                rd(2'd2, 18'h15555);
                rd(2'd3, 18'h2AAAA);
                rd(2'd1, 18'h00123);
                poke(18'h01111);
                poke(18'h02222);
                rd(2'd2, 18'h04567);
                for (int i = 0; i < 8; i++)
                    rd(2'(i), 18'((i * 20011 + 77) % 262144));
                repeat (E_ACC + E_DF + 4) @(negedge clk);
                chk(exp_q.size() == 0, "R7", "outstanding after drain",
                    32'(exp_q.size()), 0);
                chk(n_rv == 14, "R7", "rvalid count", 32'(n_rv), 14);
            end
            begin
                repeat (20000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) chk(0, "R4", "watchdog expired", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule